// File: doc/BRIEF.md
# Low-Voltage Supervisor Reset Filter

This block sits between two analog supply comparators and the core's reset logic. Each clock it receives one flag saying the supply is at or below the falling trip level and another saying the supply is above the higher rising trip level. It counts consecutive low samples and raises a reset request once the run is long enough. A single sample above the rising level withdraws the request. The filter therefore ignores short dips, and a recovered supply lets the core go at once.

Two configuration inputs control the block. One powers the supervisor down. The other stops it from issuing resets. While resets are blocked, the supervisor still tracks the supply in a low-voltage indicator with hysteresis, and software can poll that indicator. A small read port returns it in the top bit of a status byte at one fixed address.

Top module: `brownout_guard`

## Requirements
- R1: The reset request `lv_reset_o` rises at the clock edge that samples the RUN_LEN-th (default 9) consecutive cycle with `below_fall_i` high. A run of RUN_LEN-1 low cycles never asserts it.
- R2: A cycle with `below_fall_i` low breaks the run, and the next low cycle counts as the first again.
- R3: While reset is requested, one sampled cycle with `above_rise_i` high (and `below_fall_i` low) releases the request at that edge. Cycles between the two levels keep it asserted.
- R4: With `cfg_powerdown_i` = 1 the supervisor is off. From the next edge the run count is zero, the indicator reads 0 and the reset request is 0.
- R5: With `cfg_rst_inhibit_i` = 1 the reset request stays 0, but the indicator keeps tracking the supply. Clearing the inhibit during a saturated run asserts the request at the next edge.
- R6: The indicator is set by a sample with `below_fall_i` high and cleared by a sample with `above_rise_i` high, and it holds its value otherwise. `below_fall_i` wins if both flags are high.
- R7: A read (`rd_en_i` = 1) at address STATUS_ADDR (default 0x0F) returns, one cycle later, `rdata_o` = {indicator, 7'b0} with `rd_valid_o` = 1. A read at any other address returns 0 with `rd_valid_o` = 0.
- R8: Writes (`wr_en_i`, `wdata_i`) have no effect on the indicator, the reset request or any later read.
- R9: The run count saturates at RUN_LEN, so a brownout of any length keeps the reset asserted without wrapping.
- R10: After `rst_n` goes low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| below_fall_i | input | 1 | Supply at or below falling trip level |
| above_rise_i | input | 1 | Supply above rising trip level |
| cfg_powerdown_i | input | 1 | 1 turns the supervisor off |
| cfg_rst_inhibit_i | input | 1 | 1 blocks the reset request |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe (ignored) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data (ignored) |
| rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| rd_valid_o | output | 1 | Read hit the status address |
| lv_reset_o | output | 1 | Low-voltage reset request to the core |

## Verification
On every cycle the assertions check several rules. A rising reset request must coincide with a saturated run count. A non-low sample must zero the count, and the count must never exceed its limit. A rising-level sample must release the request, and the powerdown and inhibit inputs must force it low. A low sample must set the indicator, and the status read must return it in the correct bit with the unused bits zero. The exact length of the qualifying run, the restart after a glitch in the middle of a run, and the indicator staying visible under inhibit are shown only by the bench's sequences. The same holds for writes leaving later reads unchanged. A reference model follows these sequences cycle by cycle.

// File: rtl/brownout_pkg.sv
package brownout_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              ind;
        logic [DATA_W-2:0] pad;
    } status_t;
endpackage

// File: rtl/bo_run_counter.sv
module bo_run_counter #(
    parameter int RUN_LEN = 9,
    parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             low_sample,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable || !low_sample) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o       = st_q.cnt;
    assign full_next_o = (st_d.cnt == CNT_MAX);
endmodule

// File: rtl/bo_level_flag.sv
module bo_level_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic low_sample,
    input  logic high_sample,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable)          st_d.flag = 1'b0;
        else if (low_sample)  st_d.flag = 1'b1;
        else if (high_sample) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/bo_status_port.sv
module bo_status_port
    import brownout_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              indicator,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    typedef struct packed {
        status_t data;
        logic    valid;
    } port_state_t;

    port_state_t st_d, st_q;
    logic        hit;
    logic        unused_write;

    // the status byte is read-only: write strobes are absorbed here
    assign unused_write = wr_en ^ (^wdata);
    assign hit          = rd_en && (addr == STAT_A);

    always_comb begin
        st_d       = '0;
        st_d.valid = hit;
        if (hit) st_d.data.ind = indicator;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.data;
    assign rd_valid = st_q.valid;
endmodule

// File: rtl/brownout_guard.sv
module brownout_guard
    import brownout_pkg::*;
#(
    parameter int RUN_LEN     = 9,
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              below_fall_i,
    input  logic              above_rise_i,
    input  logic              cfg_powerdown_i,
    input  logic              cfg_rst_inhibit_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              rd_valid_o,
    output logic              lv_reset_o
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic req;
    } rst_state_t;

    logic             sup_en;
    logic [CNT_W-1:0] run_cnt;
    logic             run_full_next;
    logic             lv_flag;
    rst_state_t       rs_d, rs_q;

    assign sup_en = !cfg_powerdown_i;

    bo_run_counter #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (sup_en),
        .low_sample  (below_fall_i),
        .cnt_o       (run_cnt),
        .full_next_o (run_full_next)
    );

    bo_level_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (sup_en),
        .low_sample  (below_fall_i),
        .high_sample (above_rise_i),
        .flag_o      (lv_flag)
    );

    bo_status_port #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en_i),
        .wr_en     (wr_en_i),
        .addr      (addr_i),
        .wdata     (wdata_i),
        .indicator (lv_flag),
        .rdata     (rdata_o),
        .rd_valid  (rd_valid_o)
    );

    // request set by a full run, held until a rising-level sample
    always_comb begin
        rs_d.req = sup_en && !cfg_rst_inhibit_i &&
                   (run_full_next || (rs_q.req && !above_rise_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign lv_reset_o = rs_q.req;
endmodule

// File: rtl/brownout_guard_chk.sv
module brownout_guard_chk #(
    parameter int RUN_LEN     = 9,
    parameter int ADDR_W      = 8,
    parameter int STATUS_ADDR = 15,
    parameter int CNT_W       = $clog2(RUN_LEN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              below_fall_i,
    input logic              above_rise_i,
    input logic              cfg_powerdown_i,
    input logic              cfg_rst_inhibit_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        rdata_o,
    input logic              rd_valid_o,
    input logic              lv_reset_o,
    input logic [CNT_W-1:0]  run_cnt,
    input logic              lv_flag
);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(RUN_LEN);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STATUS_ADDR);

    assert_rise_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_reset_o) |-> run_cnt == CNT_MAX);

    assert_break_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !below_fall_i |=> run_cnt == '0);

    assert_rise_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_reset_o && above_rise_i && !below_fall_i) |=> !lv_reset_o);

    assert_powerdown_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_powerdown_i |=> (!lv_reset_o && run_cnt == '0 && !lv_flag));

    assert_inhibit_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_inhibit_i |=> !lv_reset_o);

    assert_low_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_powerdown_i && below_fall_i) |=> lv_flag);

    assert_status_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == STAT_A) |=>
            (rd_valid_o && rdata_o[7] == $past(lv_flag) && rdata_o[6:0] == 7'd0));

    assert_other_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i != STAT_A) |=> (!rd_valid_o && rdata_o == 8'd0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_MAX);
endmodule

bind brownout_guard brownout_guard_chk #(
    .RUN_LEN(RUN_LEN), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .below_fall_i      (below_fall_i),
    .above_rise_i      (above_rise_i),
    .cfg_powerdown_i   (cfg_powerdown_i),
    .cfg_rst_inhibit_i (cfg_rst_inhibit_i),
    .rd_en_i           (rd_en_i),
    .addr_i            (addr_i),
    .rdata_o           (rdata_o),
    .rd_valid_o        (rd_valid_o),
    .lv_reset_o        (lv_reset_o),
    .run_cnt           (run_cnt),
    .lv_flag           (lv_flag)
);

// File: tb/brownout_guard_test.sv
`timescale 1ns/1ps
module brownout_guard_test;
    localparam int RUN_LEN = 9;
    localparam logic [7:0] STAT = 8'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       below = 1'b0, above = 1'b0, pd = 1'b0, inh = 1'b0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       rd_valid, lv_reset;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_run  = 0;
    bit m_rst  = 0;
    bit m_flag = 0;
    bit m_val  = 0;
    logic [7:0] m_data = 8'h00;

    always #4 clk = ~clk;

    brownout_guard uut (
        .clk(clk), .rst_n(rst_n),
        .below_fall_i(below), .above_rise_i(above),
        .cfg_powerdown_i(pd), .cfg_rst_inhibit_i(inh),
        .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .rd_valid_o(rd_valid), .lv_reset_o(lv_reset)
    );

    task automatic compare(input string tag);
        vectors++;
        if (lv_reset !== m_rst || rdata !== m_data || rd_valid !== m_val) begin
            errors++;
            $display("FAIL %s: got reset=%0b rdata=%02h valid=%0b, expected reset=%0b rdata=%02h valid=%0b",
                     tag, lv_reset, rdata, rd_valid, m_rst, m_data, m_val);
        end
    endtask

    // apply one cycle of stimulus, advance the model, compare at the negedge
    task automatic step(input string tag, input bit b, input bit a,
                        input bit p, input bit i, input bit r,
                        input bit w, input logic [7:0] ad);
        below = b; above = a; pd = p; inh = i; rd = r; wr = w; addr = ad;
        wdata = w ? 8'hFF : 8'h00;
        @(posedge clk);
        m_val  = r && (ad == STAT);
        m_data = m_val ? {m_flag, 7'd0} : 8'h00;
        if (p)      m_run = 0;
        else if (b) m_run = (m_run < RUN_LEN) ? m_run + 1 : RUN_LEN;
        else        m_run = 0;
        m_rst = !p && !i && (m_run == RUN_LEN || (m_rst && !a));
        if (p)      m_flag = 0;
        else if (b) m_flag = 1;
        else if (a) m_flag = 0;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R10 reset state");

        // R1: eight low cycles are not enough
        for (int k = 0; k < RUN_LEN - 1; k++) step("R1 short run", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R1 short run ends", 0, 1, 0, 0, 0, 0, 8'h00);
        // R1: exactly nine asserts on the ninth
        for (int k = 0; k < RUN_LEN; k++) step("R1 full run", 1, 0, 0, 0, 0, 0, 8'h00);

        // R9: long brownout with status polling (R6, R7)
        for (int k = 0; k < 20; k++) step("R9 saturated run", 1, 0, 0, 0, 1, 0, STAT);

        // R3: between levels holds, one rising sample releases
        for (int k = 0; k < 3; k++) step("R3 hold between levels", 0, 0, 0, 0, 1, 0, STAT);
        step("R3 release", 0, 1, 0, 0, 0, 0, 8'h00);
        step("R6 cleared read", 0, 0, 0, 0, 1, 0, STAT);

        // R2: glitch restarts the count
        for (int k = 0; k < 5; k++) step("R2 pre-glitch", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R2 glitch", 0, 0, 0, 0, 0, 0, 8'h00);
        for (int k = 0; k < RUN_LEN - 1; k++) step("R2 restarted run", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R2 ninth after glitch", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R3 release again", 0, 1, 0, 0, 0, 0, 8'h00);

        // R5: inhibit blocks reset but indicator still readable
        for (int k = 0; k < 12; k++) step("R5 inhibited run", 1, 0, 0, 1, 1, 0, STAT);
        step("R5 inhibit lifted", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R3 release after inhibit", 0, 1, 0, 0, 1, 0, STAT);

        // R4: powerdown silences everything
        for (int k = 0; k < 12; k++) step("R4 powered down", 1, 0, 1, 0, 1, 0, STAT);
        for (int k = 0; k < RUN_LEN - 1; k++) step("R4 count restarts", 1, 0, 0, 0, 0, 0, 8'h00);
        step("R4 no early reset", 0, 1, 0, 0, 0, 0, 8'h00);

        // R8: writes ignored; R7: other addresses
        step("R8 write", 0, 0, 0, 0, 0, 1, STAT);
        step("R8 read after write", 0, 0, 0, 0, 1, 0, STAT);
        step("R8 write during low", 1, 0, 0, 0, 0, 1, STAT);
        step("R7 read status", 0, 0, 0, 0, 1, 0, STAT);
        step("R7 other address", 0, 0, 0, 0, 1, 0, 8'h10);
        step("R7 address zero", 0, 0, 0, 0, 1, 0, 8'h00);
        step("R6 both flags low wins", 1, 1, 0, 0, 1, 0, STAT);
        step("R6 readback", 0, 0, 0, 0, 1, 0, STAT);

        // R10: reset clears a live request
        for (int k = 0; k < RUN_LEN; k++) step("R1 run before reset", 1, 0, 0, 0, 0, 0, 8'h00);
        rst_n = 1'b0; below = 1'b0; rd = 1'b0;
        @(posedge clk);
        m_run = 0; m_rst = 0; m_flag = 0; m_val = 0; m_data = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        compare("R10 reset mid-brownout");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule